// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block turns message-signalled interrupt writes from a PCIe link into pending bits that a local CPU can see. An inbound memory write is treated as an interrupt message only when its full address equals a programmable 64-bit target, made of a low word and a high word. The high word may be zero when the target lies below 4 GiB. The write's data value is the global vector number. Vectors are grouped in sets of 32. Vector `v` belongs to group `v / 32` at bit `v % 32`.

Each group has an enable word and a pending (status) word. Both are reached through a simple 32-bit register port with combinational read data. Software enables vectors, services them, and acknowledges each one by writing a 1 to its pending bit. A single level interrupt line is raised while any enabled vector is pending. The number of groups is a parameter; the default is 8 groups, which gives 256 vectors.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the target address words, every enable word and every pending word read 0, and `irq_o` is low.
- R2: The target low word sits at byte offset 0x00 and the high word at 0x04. Each reads back the last value written to it.
- R3: An inbound write with `msi_wr_valid` high, whose address equals {high word, low word} and whose data `v` is below 32 × NUM_GROUPS, sets pending bit `v % 32` of group `v / 32` if that vector is enabled. The bit reads as set from the next cycle. This holds when the high word is zero.
- R4: An inbound write whose address differs from the target in any bit, high word included, changes no pending bit.
- R5: An inbound write whose data is 32 × NUM_GROUPS or larger changes no pending bit. Upper data bits are never discarded to form an index.
- R6: A write to a vector whose enable bit is 0 is not recorded.
- R7: Group `g` has its enable word at byte offset 0x40 + 12·g and its pending word at 0x44 + 12·g. Every other offset, including offset 0x48 + 12·g and any offset whose two low bits are not zero, reads 0 and ignores writes.
- R8: Writing the pending word clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. A pending bit cannot be set by a register write.
- R9: When an inbound write sets a pending bit in the same cycle that a register write clears it, the bit ends up set.
- R10: `irq_o` equals, one cycle late, the OR over all groups of (pending AND enable). Clearing enables therefore drops the line without losing pending bits.
- R11: A write to an enable word replaces the whole word. Only the vectors enabled at the time of the inbound write are recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_wr_valid | input | 1 | Inbound memory write present this cycle |
| msi_wr_addr | input | ADDR_W | Inbound write address |
| msi_wr_data | input | 32 | Inbound write data (vector number) |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt to the host CPU |

## Verification
Interrupt messages are sent to enabled vectors in the first and in an inner group. This shows whether the group-and-bit split and the 12-byte group stride land on the right word. They are also sent to vectors that are in range but disabled, to targets that differ only in the low or only in the high word, and with out-of-range data whose low bits name an enabled vector. These cases separate enable gating, full address matching and data truncation. Acknowledge writes with mixed zero and one bits, and a message that collides with an acknowledge of the same bit, show whether clearing is bitwise and which side has priority. Enable rewrites and the later re-enabling of a vector that is already pending show that the interrupt line follows pending AND enable one cycle late, not the pending bits alone.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
   localparam int unsigned VEC_PER_GRP   = 32;
   localparam int unsigned TGT_LO_OFS    = 'h00;
   localparam int unsigned TGT_HI_OFS    = 'h04;
   localparam int unsigned GRP_BASE_OFS  = 'h40;
   localparam int unsigned GRP_STRIDE    = 12;
   localparam int unsigned GRP_EN_OFS    = 0;
   localparam int unsigned GRP_ST_OFS    = 4;

   function automatic int unsigned grp_word_ofs(input int unsigned grp, input int unsigned sub);
      return GRP_BASE_OFS + GRP_STRIDE * grp + sub;
   endfunction
endpackage

// File: rtl/msi_cap_match.sv
module msi_cap_match #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned NVEC   = 256
) (
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic [NVEC-1:0]   set_req_o
);
   localparam int unsigned VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1;

   logic addr_hit;
   logic in_range;
   logic take;

   always_comb begin
      addr_hit  = wr_valid && (wr_addr == tgt_addr);
      in_range  = (wr_data < 32'(NVEC));
      take      = addr_hit && in_range;
      set_req_o = take ? (NVEC'(1) << wr_data[VEC_W-1:0]) : '0;
   end
endmodule

// File: rtl/msi_cap_group.sv
module msi_cap_group
   import msi_cap_pkg::*;
#(
   parameter int unsigned GRP_IDX = 0,
   parameter int unsigned REG_AW  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [REG_AW-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   input  logic [VEC_PER_GRP-1:0] set_req,
   output logic [VEC_PER_GRP-1:0] enable_o,
   output logic [VEC_PER_GRP-1:0] status_o,
   output logic [31:0]            rd_data_o
);
   localparam logic [REG_AW-1:0] EN_ADDR = REG_AW'(grp_word_ofs(GRP_IDX, GRP_EN_OFS));
   localparam logic [REG_AW-1:0] ST_ADDR = REG_AW'(grp_word_ofs(GRP_IDX, GRP_ST_OFS));

   logic [VEC_PER_GRP-1:0] enable_q;
   logic [VEC_PER_GRP-1:0] status_q;
   logic [VEC_PER_GRP-1:0] set_ok;
   logic [VEC_PER_GRP-1:0] clr_mask;
   logic                   we_en;
   logic                   we_st;

   always_comb begin
      we_en    = reg_we && (reg_addr == EN_ADDR);
      we_st    = reg_we && (reg_addr == ST_ADDR);
      set_ok   = set_req & enable_q;
      clr_mask = we_st ? reg_wdata : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         status_q <= '0;
      end else begin
         if (we_en) enable_q <= reg_wdata;
         // set has priority over a same-cycle acknowledge
         status_q <= (status_q & ~clr_mask) | set_ok;
      end
   end

   always_comb begin
      if (reg_addr == EN_ADDR)      rd_data_o = enable_q;
      else if (reg_addr == ST_ADDR) rd_data_o = status_q;
      else                          rd_data_o = '0;
   end

   assign enable_o = enable_q;
   assign status_o = status_q;

   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0)); // R6
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (we_st && ((reg_wdata & set_req) == '0)) |=> ((status_q & $past(reg_wdata)) == '0)); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ok != '0) |=> ((status_q & $past(set_ok)) == $past(set_ok))); // R9
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned REG_AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_wr_valid,
   input  logic [ADDR_W-1:0] msi_wr_addr,
   input  logic [31:0]       msi_wr_data,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_o
);
   localparam int unsigned NVEC    = NUM_GROUPS * VEC_PER_GRP;
   localparam int unsigned MAP_END = GRP_BASE_OFS + GRP_STRIDE * NUM_GROUPS;
   localparam logic [REG_AW-1:0] LO_ADDR = REG_AW'(TGT_LO_OFS);
   localparam logic [REG_AW-1:0] HI_ADDR = REG_AW'(TGT_HI_OFS);

   if (NUM_GROUPS < 1 || NUM_GROUPS > 64) begin : g_bad_groups
      $error("NUM_GROUPS must be 1..64");
   end
   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must be 33..64");
   end
   if (REG_AW > 16 || MAP_END > (1 << REG_AW)) begin : g_bad_reg_aw
      $error("REG_AW too small for the group map");
   end

   logic [31:0]       tgt_lo_q;
   logic [31:0]       tgt_hi_q;
   logic [63:0]       tgt_full;
   logic [ADDR_W-1:0] tgt_addr;
   logic [NVEC-1:0]   set_req;
   logic [NVEC-1:0]   all_en;
   logic [NVEC-1:0]   all_st;
   logic [31:0]       grp_rd [NUM_GROUPS];
   logic [31:0]       grp_rd_or;
   logic              irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_lo_q <= '0;
         tgt_hi_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == LO_ADDR) tgt_lo_q <= reg_wdata;
         if (reg_addr == HI_ADDR) tgt_hi_q <= reg_wdata;
      end
   end

   assign tgt_full = {tgt_hi_q, tgt_lo_q};
   assign tgt_addr = tgt_full[ADDR_W-1:0];

   msi_cap_match #(.ADDR_W(ADDR_W), .NVEC(NVEC)) u_match (
      .wr_valid  (msi_wr_valid),
      .wr_addr   (msi_wr_addr),
      .wr_data   (msi_wr_data),
      .tgt_addr  (tgt_addr),
      .set_req_o (set_req)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      msi_cap_group #(.GRP_IDX(g), .REG_AW(REG_AW)) u_grp (
         .clk       (clk),
         .rst_n     (rst_n),
         .reg_we    (reg_we),
         .reg_addr  (reg_addr),
         .reg_wdata (reg_wdata),
         .set_req   (set_req[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .enable_o  (all_en[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .status_o  (all_st[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .rd_data_o (grp_rd[g])
      );
   end

   always_comb begin
      grp_rd_or = '0;
      for (int g = 0; g < NUM_GROUPS; g++) grp_rd_or = grp_rd_or | grp_rd[g];
      if (reg_addr == LO_ADDR)      reg_rdata = tgt_lo_q;
      else if (reg_addr == HI_ADDR) reg_rdata = tgt_hi_q;
      else                          reg_rdata = grp_rd_or;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(all_st & all_en);
   end
   assign irq_o = irq_q;

   AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_req)); // R3
   AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!(msi_wr_valid && (msi_wr_addr == tgt_addr)) && !reg_we) |=> $stable(all_st)); // R4
   AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_wr_data >= 32'(NVEC) && !reg_we) |=> $stable(all_st)); // R5
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((all_st & all_en) == '0) |=> !irq_o); // R10
endmodule

// File: tb/sim_msi_capture_ctrl.sv
`timescale 1ns/1ps
module sim_msi_capture_ctrl;
   localparam int NG = 8;
   localparam int NV = NG * 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_wr_valid = 1'b0;
   logic [63:0] msi_wr_addr = '0;
   logic [31:0] msi_wr_data = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   msi_capture_ctrl #(.NUM_GROUPS(NG), .ADDR_W(64), .REG_AW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .msi_wr_valid(msi_wr_valid), .msi_wr_addr(msi_wr_addr),
      .msi_wr_data(msi_wr_data), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

   // behavioural reference
   logic [31:0]   m_lo, m_hi;
   logic [NV-1:0] m_en, m_st;
   logic          m_irq;
   logic          m_pend;
   int            m_g, m_r;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_en = 0; m_st = 0; m_irq = 0;
      end else begin
         m_pend = |(m_st & m_en);
         if (msi_wr_valid && msi_wr_addr == {m_hi, m_lo} && msi_wr_data < NV
             && m_en[msi_wr_data]) begin
            if (reg_we) apply_write();
            m_st[msi_wr_data] = 1'b1;
         end else if (reg_we) apply_write();
         m_irq = m_pend;
      end
   end

   task automatic apply_write();
      if (reg_addr == 8'h00) m_lo = reg_wdata;
      else if (reg_addr == 8'h04) m_hi = reg_wdata;
      else if (reg_addr >= 8'h40 && reg_addr[1:0] == 2'b00) begin
         m_g = (int'(reg_addr) - 'h40) / 12;
         m_r = (int'(reg_addr) - 'h40) % 12;
         if (m_g < NG && m_r == 0) m_en[m_g*32 +: 32] = reg_wdata;
         if (m_g < NG && m_r == 4) m_st[m_g*32 +: 32] = m_st[m_g*32 +: 32] & ~reg_wdata;
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int g, r;
      if (a == 8'h00) return m_lo;
      if (a == 8'h04) return m_hi;
      if (a < 8'h40 || a[1:0] != 2'b00) return 32'h0;
      g = (int'(a) - 'h40) / 12;
      r = (int'(a) - 'h40) % 12;
      if (g >= NG) return 32'h0;
      if (r == 0) return m_en[g*32 +: 32];
      if (r == 4) return m_st[g*32 +: 32];
      return 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R10: interrupt line compared on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) chk("R10 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
   end

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp_read(a));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic msi(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      msi_wr_valid = 1'b1; msi_wr_addr = a; msi_wr_data = d;
      @(negedge clk);
      msi_wr_valid = 1'b0;
   endtask

   task automatic msi_and_wr(input logic [63:0] ma, input logic [31:0] md,
                             input logic [7:0] ra, input logic [31:0] rdv);
      @(negedge clk);
      msi_wr_valid = 1'b1; msi_wr_addr = ma; msi_wr_data = md;
      reg_we = 1'b1; reg_addr = ra; reg_wdata = rdv;
      @(negedge clk);
      msi_wr_valid = 1'b0; reg_we = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, "R1 lo"); rd(8'h04, "R1 hi"); rd(8'h40, "R1 en0"); rd(8'h44, "R1 st0");
      rd(8'h94, "R1 en7"); rd(8'h98, "R1 st7");
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      // R2 target words
      wr(8'h00, TGT[31:0]); wr(8'h04, TGT[63:32]);
      rd(8'h00, "R2 lo"); rd(8'h04, "R2 hi");
      // R11/R7 enables at the group stride
      wr(8'h40, 32'hFFFF_FFFF); wr(8'h64, 32'h0000_0020);
      rd(8'h40, "R11 en0"); rd(8'h64, "R7 en3");
      // R3 basic capture
      msi(TGT, 7); rd(8'h44, "R3 st0 v7");
      // R3 inner group, R6 disabled neighbour
      msi(TGT, 101); rd(8'h68, "R3 st3 v101");
      msi(TGT, 102); rd(8'h68, "R6 st3 v102 disabled");
      // R4 address mismatch in high or low word
      msi({32'h0, TGT[31:0]}, 9); rd(8'h44, "R4 hi mismatch");
      msi(TGT + 64'd4, 9);        rd(8'h44, "R4 lo mismatch");
      // R5 out-of-range data
      msi(TGT, 256);          rd(8'h44, "R5 data 256");
      msi(TGT, 32'h8000_0009); rd(8'h44, "R5 data high bits");
      rd(8'h40, "R5 en0 intact");
      // R8 write-1-clear
      msi(TGT, 3); msi(TGT, 4);
      wr(8'h44, 32'h0); rd(8'h44, "R8 zero write");
      wr(8'h44, 32'h0000_0088); rd(8'h44, "R8 clear 3 and 7");
      // R9 set wins over same-cycle clear
      msi_and_wr(TGT, 4, 8'h44, 32'h0000_0010); rd(8'h44, "R9 bit4 kept");
      msi_and_wr(TGT, 6, 8'h44, 32'h0000_0010); rd(8'h44, "R9 bit6 set bit4 cleared");
      // R10 enable gating of the line
      wr(8'h40, 32'h0); wr(8'h64, 32'h0);
      repeat (2) @(negedge clk);
      chk("R10 irq off", {31'b0, irq_o}, 32'h0);
      rd(8'h44, "R10 pending kept");
      wr(8'h64, 32'h0000_0020);
      repeat (2) @(negedge clk);
      chk("R10 irq back", {31'b0, irq_o}, 32'h1);
      // R11 enable replacement
      wr(8'h68, 32'hFFFF_FFFF); wr(8'h64, 32'h0000_0001);
      msi(TGT, 101); rd(8'h68, "R11 v101 now off");
      msi(TGT, 96);  rd(8'h68, "R11 v96 now on");
      // R3 zero high word
      wr(8'h04, 32'h0); wr(8'h94, 32'h8000_0000);
      msi({32'h0, TGT[31:0]}, 255); rd(8'h98, "R3 v255 hi zero");
      // R7 unmapped and unaligned
      rd(8'h48, "R7 gap"); rd(8'hFC, "R7 beyond"); rd(8'h41, "R7 unaligned");
      wr(8'h41, 32'h0000_FFFF); rd(8'h40, "R7 unaligned write ignored");
      wr(8'h48, 32'h0000_FFFF); rd(8'h48, "R7 gap write ignored");
      wr(8'h45, 32'hFFFF_FFFF); rd(8'h44, "R8 no clear via unaligned");
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule